// File: doc/BRIEF.md
# Receive Address Match Filter

This block sits between a serial character receiver and the receive data buffer and decides, one character at a time, whether a received character is forwarded or dropped. It carries two match-address slots, each with its own enable. With both enables off, every character is forwarded. With at least one enable on, a character is treated as an address only when its tag bit, the most significant bit of the active data length, is set. Untagged characters are dropped. Tagged characters are forwarded when their address bits equal the address held in any enabled slot.

The tag bit position follows the data-length mode: bit 7 for 8-bit characters, bit 8 for 9-bit characters and bit 9 for 10-bit characters. In 9-bit and 10-bit mode the low eight data bits are compared with the full slot address. In 8-bit mode only bits 6:0 are compared, against bits 6:0 of each slot address. The pass or drop decision is combinational in the cycle of the input strobe. The forward strobe and the forwarded data are registered and appear one cycle later. A dropped character produces no strobe.

Top module: `rx_addr_filter`

## Requirements
- R1: With both enables at 0, every strobed character is forwarded unchanged, in every length mode.
- R2: With at least one enable at 1, a character whose tag bit is 0 is dropped. The tag bit is bit 7 for mode 0 (8-bit), bit 8 for mode 1 (9-bit) and bit 9 for mode 2 (10-bit).
- R3: With one enable at 1, a tagged character is forwarded only when its address bits equal that slot's address. Otherwise it is dropped.
- R4: With both enables at 1, a tagged character is forwarded when it matches either slot's address.
- R5: A slot whose enable is 0 never causes a match, even when its address equals the character's address bits.
- R6: In mode 0, only data bits 6:0 are compared with address bits 6:0, and address bit 7 is ignored. In modes 1 and 2, data bits 7:0 are compared with all 8 address bits.
- R7: `fwd_valid` rises exactly one clock after an accepted `rx_valid`, and `fwd_data` then carries that character's full 10-bit value. A dropped character, or a cycle with no `rx_valid`, gives `fwd_valid` = 0 in the next cycle.
- R8: After reset, `fwd_valid` is 0 and `fwd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 10 | Received character, right aligned |
| len_mode | input | 2 | Length mode: 0 = 8-bit, 1 = 9-bit, 2 = 10-bit (3 acts as 2) |
| addr_a | input | 8 | Match address of slot A |
| addr_b | input | 8 | Match address of slot B |
| en_a | input | 1 | Enable for slot A |
| en_b | input | 1 | Enable for slot B |
| fwd_valid | output | 1 | Forward strobe, one cycle after acceptance |
| fwd_data | output | 10 | Forwarded character |

## Verification
The bench builds the filter with its default parameters: a 10-bit character width and two match slots of 8 bits each. With these values every length mode and every combination of the two enables is reachable. It drives characters whose tag bit is set and whose address bit 7 differs from the slot address, which exercises the 7-bit comparison of 8-bit mode. It also drives back-to-back strobes, so the one-cycle registered forward is checked without idle gaps between characters.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int CHAR_W = 10;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    LEN_8  = 2'd0,
    LEN_9  = 2'd1,
    LEN_10 = 2'd2,
    LEN_XX = 2'd3
  } len_mode_e;

  // tag bit position for a length mode
  function automatic int unsigned tag_pos(input logic [1:0] mode);
    case (mode)
      2'd0:    return 7;
      2'd1:    return 8;
      default: return 9;
    endcase
  endfunction

  // mask of compared address bits for a length mode
  function automatic logic [ADDR_W-1:0] cmp_mask(input logic [1:0] mode);
    if (mode == 2'd0) return {1'b0, {(ADDR_W-1){1'b1}}};
    return {ADDR_W{1'b1}};
  endfunction
endpackage

// File: rtl/rx_tag_extract.sv
module rx_tag_extract
  import rx_addr_filter_pkg::*;
#(
  parameter int DW = CHAR_W,
  parameter int AW = ADDR_W
) (
  input  logic [DW-1:0] data,
  input  logic [1:0]    mode,
  output logic          tag,
  output logic [AW-1:0] key,
  output logic [AW-1:0] mask
);
  always_comb begin
    tag  = data[tag_pos(mode)];
    mask = cmp_mask(mode);
    key  = data[AW-1:0] & mask;
  end
endmodule

// File: rtl/rx_slot_match.sv
module rx_slot_match
  import rx_addr_filter_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] key,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  assign hit = en && ((addr & mask) == key);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int DW     = CHAR_W,
  parameter int AW     = ADDR_W,
  parameter int NSLOTS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [1:0]    len_mode,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic          en_a,
  input  logic          en_b,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data
);
  logic          tag;
  logic [AW-1:0] key, mask;
  logic [NSLOTS-1:0] slot_en, slot_hit;
  logic [AW-1:0] slot_addr [NSLOTS];
  logic filter_on, accept_now, drop_now;

  assign slot_en      = {en_b, en_a};
  assign slot_addr[0] = addr_a;
  assign slot_addr[1] = addr_b;

  rx_tag_extract #(.DW(DW), .AW(AW)) u_tag (
    .data(rx_data), .mode(len_mode), .tag(tag), .key(key), .mask(mask)
  );

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    rx_slot_match #(.AW(AW)) u_match (
      .en(slot_en[s]), .addr(slot_addr[s]), .key(key), .mask(mask),
      .hit(slot_hit[s])
    );
  end

  assign filter_on  = |slot_en;
  assign accept_now = rx_valid && (!filter_on || (tag && |slot_hit));
  assign drop_now   = rx_valid && !accept_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= accept_now;
      if (accept_now) fwd_data <= rx_data;
    end
  end

  // R2
  untagged_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && filter_on && !tag) |=> !fwd_valid);
  // R1
  pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !filter_on) |=> (fwd_valid && fwd_data == $past(rx_data)));
  // R5
  disabled_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit & ~slot_en) && !(slot_hit & ~slot_en));
  // R7
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !fwd_valid);
  // R7
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(rx_valid));
  // R3
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_now |=> !fwd_valid);
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic clk = 0, rst_n = 0, rx_valid = 0, en_a = 0, en_b = 0;
  logic [9:0] rx_data = '0;
  logic [1:0] len_mode = 0;
  logic [7:0] addr_a = '0, addr_b = '0;
  logic fwd_valid;
  logic [9:0] fwd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic v; logic [9:0] d; string req; } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  rx_addr_filter dut_i (.*);

  function automatic bit model(input logic [9:0] d, input logic [1:0] m,
                               input logic ea, input logic eb,
                               input logic [7:0] aa, input logic [7:0] ab);
    bit t; logic [7:0] k, xa, xb;
    if (!ea && !eb) return 1;
    t = (m == 0) ? d[7] : (m == 1) ? d[8] : d[9];
    if (!t) return 0;
    k = d[7:0]; xa = aa; xb = ab;
    if (m == 0) begin k[7] = 0; xa[7] = 0; xb[7] = 0; end
    return (ea && k == xa) || (eb && k == xb);
  endfunction

  task automatic send(input logic [9:0] d, input string req);
    exp_t e;
    rx_valid = 1; rx_data = d;
    e.v = model(d, len_mode, en_a, en_b, addr_a, addr_b);
    e.d = d; e.req = req;
    expq.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic idle(input string req);
    exp_t e;
    rx_valid = 0; e.v = 0; e.d = '0; e.req = req;
    expq.push_back(e);
    @(posedge clk); #1;
  endtask

  // monitor: each cycle's expectation is compared mid-cycle after the edge
  always @(posedge clk) begin
    if (rst_n && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      #3;
      checks++;
      if (fwd_valid !== e.v || (e.v && fwd_data !== e.d)) begin
        errors++;
        $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                 e.req, fwd_valid, fwd_data, e.v, e.d);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    checks++;
    if (fwd_valid !== 0 || fwd_data !== 0) begin
      errors++;
      $display("FAIL R8: valid=%0b data=%h expected 0 0", fwd_valid, fwd_data);
    end
    rst_n = 1;
    @(posedge clk); #1;
    // R1: pass-through in every mode
    for (int m = 0; m < 3; m++) begin
      len_mode = m[1:0];
      send(10'h055, "R1"); send(10'h2AA, "R1");
    end
    idle("R7");
    // R2: untagged drop per mode; R3: single slot A
    en_a = 1; addr_a = 8'h3C;
    len_mode = 0; send(10'h03C, "R2"); send(10'h0BC, "R3"); send(10'h0BD, "R3");
    len_mode = 1; send(10'h0BC, "R2"); send(10'h13C, "R3"); send(10'h13D, "R3");
    len_mode = 2; send(10'h13C, "R2"); send(10'h23C, "R3"); send(10'h2C3, "R3");
    // R6: address bit 7 ignored in 8-bit mode, used in 9-bit mode
    addr_a = 8'hBC;
    len_mode = 0; send(10'h0BC, "R6");
    addr_a = 8'h3C; send(10'h0BC, "R6");
    len_mode = 1; send(10'h1BC, "R6");
    addr_a = 8'hBC; send(10'h1BC, "R6");
    // R5: slot B has matching address but disabled
    en_a = 1; addr_a = 8'h11; en_b = 0; addr_b = 8'h22;
    send(10'h122, "R5");
    en_a = 0; en_b = 1; send(10'h111, "R5"); send(10'h122, "R3");
    // R4: both slots
    en_a = 1; en_b = 1; len_mode = 2;
    send(10'h211, "R4"); send(10'h222, "R4"); send(10'h233, "R4");
    send(10'h011, "R2");
    idle("R7"); idle("R7");
    rx_valid = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule